// File: doc/BRIEF.md
# Minimal Four-Instruction Accumulator Processor

This block is a very small processor core built around one accumulator, a program counter and a single carry flag. It has no register file. Every instruction is one memory word. The two most significant bits of the word select one of four operations. The low address bits name the memory word that the operation uses. The core drives one single-port, word-addressed memory that returns read data one cycle after the address is presented. Instruction fetches, operand reads and stores all share that one port.

The design has three parts. The address path holds the program counter and the latched operand address, and it chooses which of the two is driven onto the memory address. The data path holds the accumulator, the carry flag and an operand register. Memory read data always lands in the operand register first. The accumulator is then updated from the operand register, so a result never feeds back into itself within one step. A control state machine sequences the other two parts. Its states are `ST_FETCH`, `ST_DECODE`, `ST_READ`, `ST_CAPTURE`, `ST_EXEC`, `ST_STORE` and `ST_BRANCH`. Its transitions are as follows:
- `ST_FETCH` always moves to `ST_DECODE`.
- `ST_DECODE` moves to `ST_READ` for NOR and ADD, to `ST_STORE` for a store, and to `ST_BRANCH` for a conditional jump.
- `ST_READ` moves to `ST_CAPTURE`, and `ST_CAPTURE` moves to `ST_EXEC`.
- `ST_EXEC`, `ST_STORE` and `ST_BRANCH` each return to `ST_FETCH`.

The data width and the address width are separate parameters, for example 8/6 or 16/12. The data width must be at least the address width plus two.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word is decoded as follows. Bits [DATA_W-1:DATA_W-2] are the opcode. Bits [ADDR_W-1:0] are the operand address. Any bits between the two fields are ignored.
- R2: While `rst` is high at a rising edge, the PC, the accumulator and the carry flag are cleared, and the state machine returns to `ST_FETCH`. After reset, `mem_addr` is 0, `mem_wdata` is 0 and `mem_we` is low.
- R3: Opcode 00 sets the accumulator to the bitwise NOR of the accumulator and the addressed memory word. The carry flag is left unchanged.
- R4: Opcode 01 adds the addressed memory word to the accumulator, modulo 2^DATA_W. The carry-out of the addition is written into the carry flag.
- R5: Opcode 10 writes the accumulator to the addressed word and leaves the accumulator and the carry flag unchanged. `mem_wdata` always shows the accumulator.
- R6: Opcode 11 is a conditional jump. If the carry flag is clear, the PC is loaded with the operand address. If the carry flag is set, the carry is cleared and the PC advances by one.
- R7: Every instruction other than a taken jump advances the PC by one, modulo 2^ADDR_W, so that execution wraps from the top address to 0.
- R8: NOR and ADD take five cycles each (`ST_FETCH`, `ST_DECODE`, `ST_READ`, `ST_CAPTURE`, `ST_EXEC`). A store or jump takes three cycles each. Memory read data is expected one cycle after the address.
- R9: `mem_we` is high for exactly one cycle per store, with `mem_addr` equal to the operand address. At all other times `mem_we` is low.
- R10: Read data is captured only into the operand register, and only in `ST_CAPTURE`. The accumulator changes only in `ST_EXEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory word address (PC or operand address) |
| mem_wdata | output | DATA_W | Store data; always equal to the accumulator |
| mem_rdata | input | DATA_W | Read data, valid one cycle after `mem_addr` |
| mem_we | output | 1 | Memory write strobe, one cycle per store |

## Verification
The assertions check the following on every cycle:
- the write strobe is a single cycle;
- the accumulator and the operand register hold except in their own load states;
- a store leaves the accumulator and the carry flag untouched;
- the PC holds between instructions, steps by one, or loads the jump target;
- each finishing state returns to fetch.

Some behaviours can only be shown by the bench's programs:
- the arithmetic results and the carry-out;
- the NOR result;
- the carry dependence of the conditional jump;
- PC wrap-around;
- the exact cycle count of each instruction mix.

The bench runs each program against a reference model that computes the expected store trace.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [1:0] {
        OP_NOR   = 2'b00,
        OP_ADD   = 2'b01,
        OP_STORE = 2'b10,
        OP_JCC   = 2'b11
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_READ,
        ST_CAPTURE,
        ST_EXEC,
        ST_STORE,
        ST_BRANCH
    } state_e;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic [1:0] fetched_op,
    input  logic    carry,
    output opcode_e alu_op,
    output logic    ir_load,
    output logic    opnd_load,
    output logic    acc_load,
    output logic    pc_step,
    output logic    pc_jump,
    output logic    carry_clr,
    output logic    addr_sel,
    output logic    mem_we
);

    state_e  state_q, state_d;
    opcode_e op_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // latched opcode (R1)
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= OP_NOR;
        end else if (ir_load) begin
            op_q <= opcode_e'(fetched_op);
        end
    end

    assign alu_op = op_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:   state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (opcode_e'(fetched_op))
                    OP_NOR, OP_ADD: state_d = ST_READ;
                    OP_STORE:       state_d = ST_STORE;
                    OP_JCC:         state_d = ST_BRANCH;
                    default:        state_d = ST_FETCH;
                endcase
            end
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_EXEC;
            ST_EXEC, ST_STORE, ST_BRANCH: state_d = ST_FETCH;
            default:    state_d = ST_FETCH;
        endcase
    end

    // output decode
    always_comb begin
        ir_load   = 1'b0;
        opnd_load = 1'b0;
        acc_load  = 1'b0;
        pc_step   = 1'b0;
        pc_jump   = 1'b0;
        carry_clr = 1'b0;
        addr_sel  = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_FETCH:   addr_sel  = 1'b0;
            ST_DECODE:  ir_load   = 1'b1;
            ST_READ:    addr_sel  = 1'b1;
            ST_CAPTURE: opnd_load = 1'b1;
            ST_EXEC: begin
                acc_load = 1'b1;
                pc_step  = 1'b1;
            end
            ST_STORE: begin
                addr_sel = 1'b1;
                mem_we   = 1'b1;
                pc_step  = 1'b1;
            end
            ST_BRANCH: begin
                if (carry) begin
                    carry_clr = 1'b1;
                    pc_step   = 1'b1;
                end else begin
                    pc_jump = 1'b1;
                end
            end
            default: addr_sel = 1'b0;
        endcase
    end

    a_r9_we_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r8_done_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC || state_q == ST_STORE || state_q == ST_BRANCH)
        |=> (state_q == ST_FETCH));

    a_r10_exec_after_capture: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC) |-> ($past(state_q) == ST_CAPTURE));

    a_r8_decode_after_fetch: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

endmodule

// File: rtl/acc_cpu_addr_path.sv
module acc_cpu_addr_path #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetched_addr,
    input  logic              ir_load,
    input  logic              pc_step,
    input  logic              pc_jump,
    input  logic              addr_sel,
    output logic [ADDR_W-1:0] op_addr,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] op_addr_q;

    // program counter: wraps modulo 2^ADDR_W (R7)
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (pc_jump) begin
            pc_q <= op_addr_q;
        end else if (pc_step) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // operand address field (R1)
    always_ff @(posedge clk) begin
        if (rst) begin
            op_addr_q <= '0;
        end else if (ir_load) begin
            op_addr_q <= fetched_addr;
        end
    end

    assign op_addr  = op_addr_q;
    assign mem_addr = addr_sel ? op_addr_q : pc_q;

    a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !(pc_step || pc_jump) |=> $stable(pc_q));

    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        pc_jump |=> (pc_q == $past(op_addr_q)));

    a_r7_pc_increment: assert property (@(posedge clk) disable iff (rst)
        (pc_step && !pc_jump) |=> (pc_q == $past(pc_q) + 1'b1));

endmodule

// File: rtl/acc_cpu_data_path.sv
module acc_cpu_data_path
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rdata,
    input  logic              opnd_load,
    input  logic              acc_load,
    input  logic              carry_clr,
    input  opcode_e           alu_op,
    output logic [DATA_W-1:0] acc,
    output logic              carry
);

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] opnd_q;
    logic              carry_q;
    logic [DATA_W-1:0] nor_res;
    logic [DATA_W-1:0] sum_res;
    logic              sum_cout;

    // per-bit logic slices
    for (genvar g = 0; g < DATA_W; g++) begin : g_slice
        assign nor_res[g] = ~(acc_q[g] | opnd_q[g]);
    end

    assign {sum_cout, sum_res} = {1'b0, acc_q} + {1'b0, opnd_q};

    // operand holding register (R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
        end else if (opnd_load) begin
            opnd_q <= rdata;
        end
    end

    // accumulator and carry (R3, R4, R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (acc_load) begin
            if (alu_op == OP_ADD) begin
                acc_q   <= sum_res;
                carry_q <= sum_cout;
            end else begin
                acc_q   <= nor_res;
            end
        end else if (carry_clr) begin
            carry_q <= 1'b0;
        end
    end

    assign acc   = acc_q;
    assign carry = carry_q;

    a_r10_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !acc_load |=> $stable(acc_q));

    a_r10_operand_hold: assert property (@(posedge clk) disable iff (rst)
        !opnd_load |=> $stable(opnd_q));

    a_r6_carry_cleared: assert property (@(posedge clk) disable iff (rst)
        carry_clr |=> !carry_q);

    a_r3_nor_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (acc_load && alu_op == OP_NOR) |=> $stable(carry_q));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we
);

    localparam int OP_MSB = DATA_W - 1;
    localparam int OP_LSB = DATA_W - 2;

    opcode_e           alu_op;
    logic              ir_load, opnd_load, acc_load;
    logic              pc_step, pc_jump, carry_clr, addr_sel;
    logic              carry;
    logic [DATA_W-1:0] acc;
    logic [ADDR_W-1:0] op_addr;

    acc_cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fetched_op (mem_rdata[OP_MSB:OP_LSB]),
        .carry      (carry),
        .alu_op     (alu_op),
        .ir_load    (ir_load),
        .opnd_load  (opnd_load),
        .acc_load   (acc_load),
        .pc_step    (pc_step),
        .pc_jump    (pc_jump),
        .carry_clr  (carry_clr),
        .addr_sel   (addr_sel),
        .mem_we     (mem_we)
    );

    acc_cpu_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk          (clk),
        .rst          (rst),
        .fetched_addr (mem_rdata[ADDR_W-1:0]),
        .ir_load      (ir_load),
        .pc_step      (pc_step),
        .pc_jump      (pc_jump),
        .addr_sel     (addr_sel),
        .op_addr      (op_addr),
        .mem_addr     (mem_addr)
    );

    acc_cpu_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .rdata     (mem_rdata),
        .opnd_load (opnd_load),
        .acc_load  (acc_load),
        .carry_clr (carry_clr),
        .alu_op    (alu_op),
        .acc       (acc),
        .carry     (carry)
    );

    assign mem_wdata = acc;

    a_r5_store_keeps_state: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> ($stable(acc) && $stable(carry)));

    a_r9_store_address: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == op_addr));

endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

    localparam int DW  = 8;
    localparam int AW  = 6;
    localparam int MEM = 64;
    localparam int TMAX = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;

    always #2 clk = ~clk;

    acc_cpu #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    // memory with one-cycle read latency and a bench load port
    logic [DW-1:0] mem [MEM];
    logic          load_en = 1'b0;
    logic [AW-1:0] load_a  = '0;
    logic [DW-1:0] load_d  = '0;

    always @(posedge clk) begin
        if (load_en) mem[load_a] <= load_d;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // program image and reference model
    logic [DW-1:0] img [MEM];
    logic [DW-1:0] mdl [MEM];
    logic [AW-1:0] exp_a [TMAX];
    logic [DW-1:0] exp_d [TMAX];
    int            exp_n;
    logic [AW-1:0] got_a [TMAX];
    logic [DW-1:0] got_d [TMAX];
    int            got_n;
    logic          recording = 1'b0;

    int checks = 0;
    int fails  = 0;

    always @(negedge clk) begin
        if (recording && mem_we && got_n < TMAX) begin
            got_a[got_n] = mem_addr;
            got_d[got_n] = mem_wdata;
            got_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] enc(input logic [1:0] op, input int a);
        logic [AW-1:0] aa;
        aa = AW'(a);
        return {op, aa};
    endfunction

    // instruction-level model: fields per R1, semantics R3..R7, cycles R8
    task automatic model(input int n, output int cyc);
        logic [AW-1:0] pc;
        logic [DW-1:0] acc;
        logic          c;
        logic [DW:0]   s;
        cyc = 0; pc = '0; acc = '0; c = 1'b0; exp_n = 0;
        for (int i = 0; i < MEM; i++) mdl[i] = img[i];
        for (int k = 0; k < n; k++) begin
            logic [DW-1:0] w;
            logic [AW-1:0] a;
            w = mdl[pc];
            a = w[AW-1:0];
            case (w[DW-1:DW-2])
                2'b00: begin acc = ~(acc | mdl[a]); pc = pc + 1'b1; cyc += 5; end
                2'b01: begin
                    s = {1'b0, acc} + {1'b0, mdl[a]};
                    acc = s[DW-1:0]; c = s[DW]; pc = pc + 1'b1; cyc += 5;
                end
                2'b10: begin
                    mdl[a] = acc;
                    if (exp_n < TMAX) begin exp_a[exp_n] = a; exp_d[exp_n] = acc; exp_n++; end
                    pc = pc + 1'b1; cyc += 3;
                end
                default: begin
                    if (!c) pc = a;
                    else begin c = 1'b0; pc = pc + 1'b1; end
                    cyc += 3;
                end
            endcase
        end
    endtask

    task automatic run(input int n, input string tag);
        int cyc;
        model(n, cyc);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < MEM; i++) begin
            load_en = 1'b1; load_a = AW'(i); load_d = img[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        // R2: reset state visible at the ports (acc from previous run cleared)
        chk(mem_addr == '0, "R2", {tag, " reset mem_addr"}, int'(mem_addr), 0);
        chk(mem_wdata == '0, "R2", {tag, " reset mem_wdata"}, int'(mem_wdata), 0);
        chk(mem_we == 1'b0, "R2", {tag, " reset mem_we"}, int'(mem_we), 0);
        got_n = 0;
        rst = 1'b0;
        recording = 1'b1;
        repeat (cyc) @(negedge clk);
        recording = 1'b0;
        // R8/R9: exactly the modelled stores within the modelled cycle count
        chk(got_n == exp_n, "R8", {tag, " store count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_a[i] == exp_a[i], "R9", {tag, " store addr"}, int'(got_a[i]), int'(exp_a[i]));
            chk(got_d[i] == exp_d[i], "R5", {tag, " store data"}, int'(got_d[i]), int'(exp_d[i]));
        end
    endtask

    initial begin
        #(4 * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);

        // Directed D1: ADD with carry-out, carry survives store, jump behaviour, NOR
        for (int i = 0; i < MEM; i++) img[i] = '0;
        img[0] = enc(2'b01, 32);   // ADD [32]  -> F0
        img[1] = enc(2'b01, 33);   // ADD [33]  -> 10, carry 1 (R4)
        img[2] = enc(2'b10, 40);   // STORE [40]
        img[3] = enc(2'b11, 10);   // JCC 10: carry set -> not taken (R6)
        img[4] = enc(2'b10, 41);   // STORE [41]
        img[5] = enc(2'b11, 8);    // JCC 8: carry clear -> taken (R6)
        img[8] = enc(2'b00, 34);   // NOR [34] -> E0 (R3)
        img[9] = enc(2'b10, 42);   // STORE [42]
        img[32] = 8'hF0; img[33] = 8'h20; img[34] = 8'h0F;
        run(8, "D1");
        chk(got_d[0] == 8'h10, "R4", "D1 add wrap result", int'(got_d[0]), 'h10);
        chk(got_a[1] == 6'd41 && got_d[1] == 8'h10, "R6", "D1 carry-set jump falls through",
            int'(got_a[1]), 41);
        chk(got_a[2] == 6'd42, "R6", "D1 carry-clear jump taken", int'(got_a[2]), 42);
        chk(got_d[2] == 8'hE0, "R3", "D1 nor result", int'(got_d[2]), 'hE0);

        // Directed D2: PC wrap from the top address (R7)
        for (int i = 0; i < MEM; i++) img[i] = '0;
        img[0]  = enc(2'b10, 50);
        img[1]  = enc(2'b11, 63);
        img[63] = enc(2'b01, 40);
        img[40] = 8'h01;
        run(8, "D2");
        for (int i = 0; i < 3; i++)
            chk(got_d[i] == DW'(i), "R7", "D2 wrap store value", int'(got_d[i]), i);

        // Directed D3: repeated store leaves acc unchanged, NOR of all-ones (R5, R10)
        for (int i = 0; i < MEM; i++) img[i] = '0;
        img[0] = enc(2'b00, 20);   // NOR with 00 -> FF
        img[1] = enc(2'b10, 30);
        img[2] = enc(2'b10, 31);
        img[3] = enc(2'b00, 21);   // NOR FF|55 -> 00
        img[4] = enc(2'b10, 32);
        img[20] = 8'h00; img[21] = 8'h55;
        run(5, "D3");
        chk(got_d[1] == 8'hFF, "R5", "D3 second store same acc", int'(got_d[1]), 'hFF);
        chk(got_d[2] == 8'h00, "R10", "D3 nor from captured operand", int'(got_d[2]), 0);

        // Random programs: random words decoded per R1, compared with the model
        for (int p = 0; p < 10; p++) begin
            for (int i = 0; i < MEM; i++) img[i] = DW'($urandom);
            run(40, "RND R1");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule